// File: doc/BRIEF.md
# Shared-RAM Register Mailbox Bridge

This block lets a host reach the register file of an infrared controller without any direct decode of those registers. The host has only a two-byte port: one byte selects a location in a small shared byte RAM, the other reads or writes the RAM byte at that location. A hardware agent sits between the RAM and the controller's register file. It watches a request byte. When the host posts a write request or a read request there, the agent carries out the register access using a register index and a value that the host has placed in two neighbouring RAM bytes. It then returns the request byte to idle, which tells the host that the access is complete.

When no request is pending, the agent refreshes a set of fixed RAM locations in a round-robin scan. These hold a copy of the controller's interrupt code, the receive buffer status, and the received bytes themselves. The host can therefore watch reception by reading RAM alone. A small stub register file holds six plain read/write registers, a read-only interrupt code register and a receive status register. A receive buffer behind the status register is filled from an input strobe.

Top module: `mailbox_bridge`

## Requirements
- R1: After reset, the host index reads 0, every RAM byte reads 0 while the interrupt code input is 0, and plain registers 0 to 5 read 0.
- R2: A host write at port offset 0 loads the low 6 bits of the data as the RAM index. A read at offset 0 returns that index. Offset 1 reads or writes the RAM byte at the index. The index does not advance on data accesses.
- R3: Request code 1 placed at RAM byte 0x1A writes the byte at 0x1C into the register selected by the low 3 bits of the byte at 0x1B. The request byte still reads 1 one cycle after the host's write and reads 0 two cycles after it.
- R4: Request code 2 places the selected register's value in RAM byte 0x1C and returns the request byte to 0 with the same two-cycle timing as R3.
- R5: A host write to byte 0x1A while it holds a nonzero code is dropped, so the pending request completes unchanged.
- R6: Any other nonzero request code returns to 0 with the same timing and touches no register.
- R7: Register 6 reads the interrupt code input and ignores writes. Register 7 reads the receive byte count in bits 5:0, and any write to register 7 empties the receive buffer.
- R8: While idle, the agent copies the interrupt code to RAM byte 0x1E and the receive status to 0x1F, at least once in every 34 cycles.
- R9: Each cycle the receive strobe is high, one byte is appended to the buffer, up to 32 bytes. Strobes beyond 32 are dropped. The agent copies buffer entry k to RAM byte 0x20+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_addr | input | 1 | Host port offset: 0 index, 1 data |
| hp_we | input | 1 | Host write strobe |
| hp_wdata | input | 8 | Host write data |
| hp_rdata | output | 8 | Host read data (combinational) |
| irq_code | input | 8 | Interrupt code shown in register 6 |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Received byte |

## Verification
A request is posted at some clock edge t. The agent acts at edge t+1, so a read result is in byte 0x1C from then on, and it clears the request byte at edge t+2. The bench therefore samples the request byte exactly at the falling edges after t+1 and t+2, and expects the posted code and then 0. Mirrored bytes can lag by up to one scan of 34 idle cycles, so the bench waits 40 cycles after changing the interrupt code or the receive buffer before it reads the mirror area. The RAM and the index are combinational on the read side, so host reads are sampled in the same half cycle in which the offset is set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // fixed RAM layout (byte addresses)
  localparam int unsigned LOC_MODE = 8'h1A;
  localparam int unsigned LOC_RIDX = 8'h1B;
  localparam int unsigned LOC_RVAL = 8'h1C;
  localparam int unsigned LOC_IRQ  = 8'h1E;
  localparam int unsigned LOC_STAT = 8'h1F;
  localparam int unsigned LOC_BUF  = 8'h20;

  typedef enum logic [7:0] {
    REQ_IDLE  = 8'd0,
    REQ_WRITE = 8'd1,
    REQ_READ  = 8'd2
  } req_code_e;

  typedef enum logic {
    AG_SCAN = 1'b0,
    AG_ACK  = 1'b1
  } agent_state_e;
endpackage

// File: rtl/mbx_ram.sv
module mbx_ram
  import mbx_pkg::*;
#(
  parameter int AW = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    mode_o,
  output logic [IW-1:0] ridx_o,
  output logic [7:0]    rval_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  // host write is applied last, so it wins an address clash
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (a_we) mem_q[a_addr] <= a_wdata;
      if (h_we) mem_q[h_addr] <= h_wdata;
    end
  end

  logic [7:0] ridx_full;
  assign h_rdata   = mem_q[h_addr];
  assign mode_o    = mem_q[AW'(LOC_MODE)];
  assign ridx_full = mem_q[AW'(LOC_RIDX)];
  assign ridx_o    = ridx_full[IW-1:0];
  assign rval_o    = mem_q[AW'(LOC_RVAL)];
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
  parameter int NREG  = 8,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(NREG)-1:0]    addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  input  logic [7:0]                 irq_code,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  input  logic [$clog2(DEPTH)-1:0]   buf_addr,
  output logic [7:0]                 buf_data,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int RAW   = $clog2(NREG);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PLAIN = NREG - 2;
  localparam logic [RAW-1:0] IRQ_IDX  = RAW'(NREG - 2);
  localparam logic [RAW-1:0] STAT_IDX = RAW'(NREG - 1);

  logic [7:0]    store_q [NREG];
  logic [7:0]    buf_q   [DEPTH];
  logic [CW-1:0] count_q, count_d;
  logic          clr, push;

  assign clr  = we && (addr == STAT_IDX);
  assign push = rx_valid && (count_q < CW'(DEPTH));

  // plain registers, one enable per slot
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g < PLAIN) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        store_q[g] <= '0;
        else if (we && addr == RAW'(g))    store_q[g] <= wdata;
      end
    end else begin : g_fixed
      assign store_q[g] = '0;
    end
  end

  always_comb begin
    count_d = count_q;
    if (clr)       count_d = '0;
    else if (push) count_d = count_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else if (push && !clr) begin
      buf_q[count_q[CW-2:0]] <= rx_data;
    end
  end

  always_comb begin
    if (addr == IRQ_IDX)       rdata = irq_code;
    else if (addr == STAT_IDX) rdata = 8'(count_q);
    else                       rdata = store_q[addr];
  end

  assign buf_data = buf_q[buf_addr];
  assign count_o  = count_q;
endmodule

// File: rtl/mbx_agent.sv
module mbx_agent
  import mbx_pkg::*;
#(
  parameter int AW    = 6,
  parameter int RAW   = 3,
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               mode_b,
  input  logic [RAW-1:0]           ridx_b,
  input  logic [7:0]               rval_b,
  input  logic [7:0]               reg_rdata,
  input  logic [7:0]               irq_code,
  input  logic [CW-1:0]            count,
  input  logic [7:0]               buf_data,
  output logic                     ram_we,
  output logic [AW-1:0]            ram_addr,
  output logic [7:0]               ram_wdata,
  output logic                     reg_we,
  output logic [RAW-1:0]           reg_addr,
  output logic [7:0]               reg_wdata,
  output logic [$clog2(DEPTH)-1:0] buf_addr,
  output logic                     ack_o
);
  localparam int SPAN = DEPTH + 2;
  localparam int SW   = $clog2(SPAN);
  localparam int BAW  = $clog2(DEPTH);

  agent_state_e  state_q, state_d;
  logic [SW-1:0] scan_q, scan_d;

  always_comb begin
    state_d   = state_q;
    scan_d    = scan_q;
    ram_we    = 1'b0;
    ram_addr  = AW'(LOC_MODE);
    ram_wdata = '0;
    reg_we    = 1'b0;
    reg_addr  = ridx_b;
    reg_wdata = rval_b;
    buf_addr  = BAW'(scan_q - SW'(2));
    case (state_q)
      AG_ACK: begin
        ram_we    = 1'b1;
        ram_addr  = AW'(LOC_MODE);
        ram_wdata = REQ_IDLE;
        state_d   = AG_SCAN;
      end
      default: begin
        if (mode_b == REQ_WRITE) begin
          reg_we  = 1'b1;
          state_d = AG_ACK;
        end else if (mode_b == REQ_READ) begin
          ram_we    = 1'b1;
          ram_addr  = AW'(LOC_RVAL);
          ram_wdata = reg_rdata;
          state_d   = AG_ACK;
        end else if (mode_b != REQ_IDLE) begin
          state_d = AG_ACK;
        end else begin
          ram_we = 1'b1;
          if (scan_q == SW'(0)) begin
            ram_addr  = AW'(LOC_IRQ);
            ram_wdata = irq_code;
          end else if (scan_q == SW'(1)) begin
            ram_addr  = AW'(LOC_STAT);
            ram_wdata = 8'(count);
          end else begin
            ram_addr  = AW'(LOC_BUF) + AW'(buf_addr);
            ram_wdata = buf_data;
          end
          scan_d = (scan_q == SW'(SPAN - 1)) ? '0 : scan_q + SW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AG_SCAN;
      scan_q  <= '0;
    end else begin
      state_q <= state_d;
      scan_q  <= scan_d;
    end
  end

  assign ack_o = (state_q == AG_ACK);
endmodule

// File: rtl/mailbox_bridge.sv
module mailbox_bridge
  import mbx_pkg::*;
#(
  parameter int RAM_AW     = 6,
  parameter int FIFO_DEPTH = 32,
  parameter int NREG       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hp_addr,
  input  logic       hp_we,
  input  logic [7:0] hp_wdata,
  output logic [7:0] hp_rdata,
  input  logic [7:0] irq_code,
  input  logic       rx_valid,
  input  logic [7:0] rx_data
);
  localparam int RAW   = $clog2(NREG);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int BAW   = $clog2(FIFO_DEPTH);

  logic [RAM_AW-1:0] index_q;
  logic [7:0]        ram_hrd, mode_b, rval_b, reg_rdata, reg_wdata, buf_data;
  logic [7:0]        ag_wdata;
  logic [RAW-1:0]    ridx_b, reg_addr;
  logic [RAM_AW-1:0] ag_addr;
  logic [BAW-1:0]    buf_addr;
  logic [CNT_W-1:0]  rx_count;
  logic              ag_we, reg_we, ack, host_ram_we, mode_busy;

  // index register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 index_q <= '0;
    else if (hp_we && !hp_addr) index_q <= hp_wdata[RAM_AW-1:0];
  end

  // a posted request is locked until the agent returns it to idle
  assign mode_busy   = (index_q == RAM_AW'(LOC_MODE)) && (mode_b != REQ_IDLE);
  assign host_ram_we = hp_we && hp_addr && !mode_busy;
  assign hp_rdata    = hp_addr ? ram_hrd : 8'(index_q);

  mbx_ram #(.AW(RAM_AW), .IW(RAW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .h_we(host_ram_we), .h_addr(index_q), .h_wdata(hp_wdata), .h_rdata(ram_hrd),
    .a_we(ag_we), .a_addr(ag_addr), .a_wdata(ag_wdata),
    .mode_o(mode_b), .ridx_o(ridx_b), .rval_o(rval_b)
  );

  mbx_regfile #(.NREG(NREG), .DEPTH(FIFO_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .irq_code(irq_code), .rx_valid(rx_valid), .rx_data(rx_data),
    .buf_addr(buf_addr), .buf_data(buf_data), .count_o(rx_count)
  );

  mbx_agent #(.AW(RAM_AW), .RAW(RAW), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_agent (
    .clk(clk), .rst_n(rst_n),
    .mode_b(mode_b), .ridx_b(ridx_b), .rval_b(rval_b), .reg_rdata(reg_rdata),
    .irq_code(irq_code), .count(rx_count), .buf_data(buf_data),
    .ram_we(ag_we), .ram_addr(ag_addr), .ram_wdata(ag_wdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .buf_addr(buf_addr), .ack_o(ack)
  );
endmodule

// File: rtl/mailbox_bridge_chk.sv
module mailbox_bridge_chk #(
  parameter int AW    = 6,
  parameter int RAW   = 3,
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hp_addr,
  input logic           hp_we,
  input logic [7:0]     hp_wdata,
  input logic [AW-1:0]  index_q,
  input logic [7:0]     mode_b,
  input logic           ack,
  input logic           reg_we,
  input logic [RAW-1:0] reg_addr,
  input logic           rx_valid,
  input logic [CW-1:0]  rx_count
);
  logic clr;
  assign clr = reg_we && (reg_addr == RAW'(2 ** RAW - 1));

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_we && !hp_addr) |=> (index_q == $past(hp_wdata[AW-1:0])));

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_we && hp_addr && index_q == AW'(8'h1A) && mode_b != 8'd0 && !ack)
      |=> (mode_b == $past(mode_b)));

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (mode_b == 8'd0));

  // R4
  req_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && mode_b != 8'd0) |=> ack);

  // R9
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  // R9
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !clr && rx_count < CW'(DEPTH))
      |=> (rx_count == CW'($past(rx_count) + 1)));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rx_count == '0));
endmodule

bind mailbox_bridge mailbox_bridge_chk #(
  .AW(RAM_AW), .RAW(RAW), .DEPTH(FIFO_DEPTH), .CW(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hp_addr(hp_addr), .hp_we(hp_we),
  .hp_wdata(hp_wdata), .index_q(index_q), .mode_b(mode_b), .ack(ack),
  .reg_we(reg_we), .reg_addr(reg_addr), .rx_valid(rx_valid),
  .rx_count(rx_count)
);

// File: tb/mailbox_bridge_bench.sv
module mailbox_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hp_addr, hp_we, rx_valid;
  logic [7:0] hp_wdata, irq_code, rx_data;
  logic [7:0] hp_rdata;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [7:0] model [6];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mailbox_bridge u_mailbox_bridge (
    .clk(clk), .rst_n(rst_n), .hp_addr(hp_addr), .hp_we(hp_we),
    .hp_wdata(hp_wdata), .hp_rdata(hp_rdata), .irq_code(irq_code),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic a, input logic [7:0] d);
    @(negedge clk);
    hp_addr = a; hp_we = 1'b1; hp_wdata = d;
    @(negedge clk);
    hp_we = 1'b0;
  endtask

  task automatic hr(input logic a, output logic [7:0] d);
    hp_addr = a;
    #1 d = hp_rdata;
  endtask

  task automatic ram_wr(input logic [7:0] a, input logic [7:0] d);
    hw(1'b0, a); hw(1'b1, d);
  endtask

  task automatic ram_rd(input logic [7:0] a, output logic [7:0] d);
    hw(1'b0, a); hr(1'b1, d);
  endtask

  // post a request, check the two-cycle handshake, return byte 0x1C
  task automatic request(input string req, input logic [7:0] code, input logic [7:0] idx,
                         input logic [7:0] val, output logic [7:0] res);
    logic [7:0] m;
    ram_wr(8'h1B, idx);
    ram_wr(8'h1C, val);
    ram_wr(8'h1A, code);
    @(negedge clk); hr(1'b1, m); chk({req, " pending"}, m, code);
    @(negedge clk); hr(1'b1, m); chk({req, " idle"}, m, 8'h00);
    ram_rd(8'h1C, res);
  endtask

  task automatic wait_mirror();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    logic [7:0] got, v;
    rst_n = 1'b0; hp_addr = 1'b0; hp_we = 1'b0; hp_wdata = '0;
    irq_code = 8'h00; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hr(1'b0, got); chk("R1 index", got, 8'h00);
    for (int a = 0; a < 64; a++) begin
      ram_rd(8'(a), got); chk("R1 ram byte", got, 8'h00);
    end
    for (int r = 0; r < 6; r++) begin
      request("R1 reg", 8'd2, 8'(r), 8'hFF, got); chk("R1 reg value", got, 8'h00);
      model[r] = 8'h00;
    end

    // R2 index port, no auto-increment
    hw(1'b0, 8'hC5);
    hr(1'b0, got); chk("R2 index low bits", got, 8'h05);
    hw(1'b1, 8'h11); hw(1'b1, 8'h22);
    hr(1'b1, got); chk("R2 same byte", got, 8'h22);
    hr(1'b0, got); chk("R2 index held", got, 8'h05);
    ram_rd(8'h06, got); chk("R2 neighbour untouched", got, 8'h00);

    // R3/R4/R7 sweep over every register
    irq_code = 8'h3C;
    for (int r = 0; r < 8; r++) begin
      for (int p = 0; p < 4; p++) begin
        v = 8'((r * 37 + p * 91 + 5) & 255);
        request("R3 write", 8'd1, 8'(r), v, got);
        if (r < 6) model[r] = v;
        request("R4 read", 8'd2, 8'(r), 8'h00, got);
        if (r < 6)       chk("R4 plain reg", got, v);
        else if (r == 6) chk("R7 irq reg", got, 8'h3C);
        else             chk("R7 status reg", got, 8'h00);
      end
    end
    // R3 upper index bits ignored
    request("R3 high idx", 8'd1, 8'h09, 8'h77, got); model[1] = 8'h77;
    request("R3 readback", 8'd2, 8'h01, 8'h00, got); chk("R3 idx low bits", got, 8'h77);

    // R5 write to busy request byte is dropped
    ram_wr(8'h1B, 8'h02);
    ram_wr(8'h1C, 8'hEE);
    ram_wr(8'h1A, 8'h02);
    hw(1'b1, 8'h01);
    hr(1'b1, got); chk("R5 idle after drop", got, 8'h00);
    ram_rd(8'h1C, got); chk("R5 read completed", got, model[2]);
    request("R5 reg", 8'd2, 8'h02, 8'h00, got); chk("R5 no write", got, model[2]);

    // R6 unknown codes
    for (int c = 3; c < 256; c += 84) begin
      request("R6 code", 8'(c), 8'h03, 8'h99, got);
      request("R6 reg", 8'd2, 8'h03, 8'h00, got); chk("R6 untouched", got, model[3]);
    end

    // R8 interrupt mirror
    irq_code = 8'hA5; wait_mirror();
    ram_rd(8'h1E, got); chk("R8 irq mirror", got, 8'hA5);
    ram_rd(8'h1F, got); chk("R8 status mirror", got, 8'h00);

    // R9 receive copy, partial fill
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(k * 7 + 3);
    end
    @(negedge clk); rx_valid = 1'b0;
    wait_mirror();
    ram_rd(8'h1F, got); chk("R8 count mirror", got, 8'd5);
    for (int k = 0; k < 5; k++) begin
      ram_rd(8'(32 + k), got); chk("R9 byte copy", got, 8'(k * 7 + 3));
    end
    request("R7 status", 8'd2, 8'h07, 8'h00, got); chk("R7 count", got, 8'd5);
    request("R7 reg6 write", 8'd1, 8'h06, 8'h00, got);
    request("R7 reg6", 8'd2, 8'h06, 8'h00, got); chk("R7 irq read-only", got, 8'hA5);

    // R7 clear, then R9 overflow
    request("R7 clear", 8'd1, 8'h07, 8'h00, got);
    wait_mirror();
    ram_rd(8'h1F, got); chk("R7 cleared mirror", got, 8'd0);
    for (int k = 0; k < 35; k++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'((k * 13 + 1) & 255);
    end
    @(negedge clk); rx_valid = 1'b0;
    wait_mirror();
    ram_rd(8'h1F, got); chk("R9 count saturates", got, 8'd32);
    for (int k = 0; k < 32; k++) begin
      ram_rd(8'(32 + k), got); chk("R9 full copy", got, 8'((k * 13 + 1) & 255));
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule